// File: doc/BRIEF.md
# External Register Bus Controller with Per-Address Wait States

This block runs single accesses on a 16-bit external register bus that has eight register addresses. A requester presents an address, a direction and write data; the controller latches the address onto the bus, pulls a low-active enable strobe, and sets a direction line. The direction line goes low only while write data is being driven.

Each of the lower seven addresses carries a 2-bit wait code in a configuration word. The code can lengthen reads, writes, both or neither by exactly one cycle. A hold input from the peripheral can stretch the strobe further, one cycle for each clock edge at which it is seen high during the access. When the access completes, a single-cycle done pulse is raised. For reads, the captured data is presented with that pulse.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset the strobe `bus_en_n` is high, `bus_dir` is high, `bus_oe` is low, `done` and `busy` are low, and `bus_addr` is 0.
- R2: An access with no wait and no hold keeps the strobe low for exactly one cycle. `done` is high in the cycle right after the strobe returns high.
- R3: The wait code of address n sits in `wait_cfg[2n+1:2n]` for n from 0 to 6. Bit 0 of the code adds one cycle to writes and bit 1 adds one cycle to reads, so 00 adds nothing, 01 adds to writes only, 10 adds to reads only and 11 adds to both.
- R4: Address 7 never receives an automatic wait, whatever `wait_cfg` holds.
- R5: While a write strobe is low, `bus_dir` is low and `bus_oe` is high. At all other times `bus_dir` is high and `bus_oe` is low.
- R6: `ext_hold` is sampled on rising edges during an access, once any automatic wait has run. Each edge that sees it high keeps the strobe low one more cycle. During that time the address, direction and write data stay stable.
- R7: `ext_hold` has no effect while the controller is idle: the strobe stays high and `busy` stays low.
- R8: For a read, `rdata` takes the value on `bus_din` at the clock edge that ends the strobe, and presents it together with `done`.
- R9: `bus_addr` keeps the address of the last access after that access has ended.
- R10: `done` lasts one cycle per access. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start an access; taken only while idle |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_addr | input | 3 | Register address of the access |
| req_wdata | input | 16 | Write data |
| wait_cfg | input | 14 | Wait codes, two bits per address 0..6 |
| ext_hold | input | 1 | Peripheral hold, high stretches the access |
| bus_din | input | 16 | Read data from the bus |
| busy | output | 1 | Access in progress |
| bus_addr | output | 3 | Latched register address |
| bus_dir | output | 1 | Low while write data is driven |
| bus_en_n | output | 1 | Access strobe, active low |
| bus_oe | output | 1 | Enable for the write data drivers |
| bus_dout | output | 16 | Write data to the bus |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is an automatic wait combined with a hold. The hold must already be high at the edge where the automatic wait is consumed, and it must not be counted there. The driver therefore raises `ext_hold` right after the accept edge and keeps it for the wait count plus the hold count. Each access in the scoreboard should then show a strobe exactly one cycle longer per hold edge. A further access keeps `req_valid` asserted with a different address throughout a long hold. Any spurious second acceptance then appears as an extra done with no matching expected item.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_WAIT = 2'd2
    } xb_state_e;

    localparam int WCODE_W      = 2;
    localparam int WCODE_WR_BIT = 0;
    localparam int WCODE_RD_BIT = 1;

endpackage

// File: rtl/xbus_wait_lookup.sv
module xbus_wait_lookup
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int N_WAIT_ADDR = 7,
    localparam int CFG_W      = N_WAIT_ADDR * WCODE_W,
    localparam int N_ADDR     = 1 << ADDR_W
) (
    input  logic [CFG_W-1:0]  cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    output logic              need_wait
);

    logic [WCODE_W-1:0] code_tab [N_ADDR];

    for (genvar n = 0; n < N_ADDR; n++) begin : g_code
        if (n < N_WAIT_ADDR) begin : g_cfg
            assign code_tab[n] = cfg[n*WCODE_W +: WCODE_W];
        end else begin : g_none
            assign code_tab[n] = '0;
        end
    end

    logic [WCODE_W-1:0] sel_code;

    always_comb begin
        sel_code  = code_tab[addr];
        need_wait = is_write ? sel_code[WCODE_WR_BIT] : sel_code[WCODE_RD_BIT];
    end

    // R4: addresses above the coded range never wait
    always_comb begin
        if (int'(addr) >= N_WAIT_ADDR) begin
            p_no_wait_high_addr_r4: assert (!need_wait);
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              need_wait,
    input  logic              ext_hold,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dir,
    output logic              bus_en_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    typedef struct packed {
        xb_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              wait_pend;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.state     = ST_ACT;
                    r_d.addr      = req_addr;
                    r_d.write     = req_write;
                    r_d.wdata     = req_wdata;
                    r_d.wait_pend = need_wait;
                end
            end
            ST_ACT: begin
                if (r_q.wait_pend) begin
                    r_d.state     = ST_WAIT;
                    r_d.wait_pend = 1'b0;
                end else if (!ext_hold) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    if (!r_q.write) r_d.rdata = bus_din;
                end
            end
            ST_WAIT: begin
                if (!ext_hold) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    if (!r_q.write) r_d.rdata = bus_din;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, write: 1'b0, wdata: '0,
                     wait_pend: 1'b0, rdata: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy     = (r_q.state != ST_IDLE);
        bus_en_n = !busy;
        bus_dir  = !(busy && r_q.write);
        bus_oe   = busy && r_q.write;
        bus_addr = r_q.addr;
        bus_dout = r_q.wdata;
        rdata    = r_q.rdata;
        done     = r_q.done;
    end

    // R6: bus contents frozen while the strobe stays low
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en_n && $past(!bus_en_n)) |->
            ($stable(bus_addr) && $stable(bus_dir) && $stable(bus_dout)));

    // R6: a hold seen during the wait cycle keeps the strobe low
    p_hold_extends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && ext_hold) |=> !bus_en_n);

    // R3: a pending automatic wait always adds a strobe cycle
    p_wait_adds_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACT && r_q.wait_pend) |=> !bus_en_n);

    // R10: completion pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: done follows the end of a strobe
    p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_en_n && $past(!bus_en_n)));

    // R7: idle with no request leaves the strobe high, hold or not
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> bus_en_n);

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 16,
    parameter int N_WAIT_ADDR = 7,
    localparam int CFG_W      = N_WAIT_ADDR * WCODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CFG_W-1:0]  wait_cfg,
    input  logic              ext_hold,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dir,
    output logic              bus_en_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic need_wait;

    xbus_wait_lookup #(
        .ADDR_W      (ADDR_W),
        .N_WAIT_ADDR (N_WAIT_ADDR)
    ) u_lookup (
        .cfg       (wait_cfg),
        .addr      (req_addr),
        .is_write  (req_write),
        .need_wait (need_wait)
    );

    xbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .need_wait (need_wait),
        .ext_hold  (ext_hold),
        .bus_din   (bus_din),
        .busy      (busy),
        .bus_addr  (bus_addr),
        .bus_dir   (bus_dir),
        .bus_en_n  (bus_en_n),
        .bus_oe    (bus_oe),
        .bus_dout  (bus_dout),
        .rdata     (rdata),
        .done      (done)
    );

    // R5: data drivers on only during a low write strobe
    p_drive_only_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!bus_en_n && !bus_dir));

endmodule

// File: tb/xbus_wait_ctrl_bench.sv
module xbus_wait_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [13:0] wait_cfg = '0;
    logic        ext_hold = 1'b0;
    logic [15:0] bus_din;
    logic        busy, bus_dir, bus_en_n, bus_oe, done;
    logic [2:0]  bus_addr;
    logic [15:0] bus_dout, rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_wait_ctrl u_xbus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_cfg(wait_cfg),
        .ext_hold(ext_hold), .bus_din(bus_din), .busy(busy), .bus_addr(bus_addr),
        .bus_dir(bus_dir), .bus_en_n(bus_en_n), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .rdata(rdata), .done(done)
    );

    // peripheral model: takes write data while the write strobe is low,
    // shows register contents only while the strobe is low
    logic [15:0] periph [8];
    initial for (int i = 0; i < 8; i++) periph[i] = 16'h1000 + 16'(i);
    always @(negedge clk) if (!bus_en_n && !bus_dir) periph[bus_addr] <= bus_dout;
    assign bus_din = !bus_en_n ? periph[bus_addr] : 16'hBAD0;

    typedef struct {
        logic [2:0]  addr;
        logic        wr;
        int          len;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] shadow [8];
    initial for (int i = 0; i < 8; i++) shadow[i] = 16'h1000 + 16'(i);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R3/R4: independent wait computation from the configuration word
    function automatic int exp_wait(input logic [2:0] a, input logic wr, input logic [13:0] cfg);
        logic [1:0] code;
        if (a == 3'd7) return 0;
        code = cfg[2*a +: 2];
        return wr ? int'(code[0]) : int'(code[1]);
    endfunction

    // monitor: counts strobe-low cycles and compares at each done
    int  low_cnt = 0;
    bit  dir_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_en_n) begin
                low_cnt++;
                if (sb.size() > 0 && (bus_dir != !sb[0].wr || bus_oe != sb[0].wr)) dir_bad = 1'b1;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(low_cnt == e.len, {e.tag, " strobe length"}, low_cnt, e.len);
                    check(bus_addr == e.addr, "R9 address on bus", bus_addr, e.addr);
                    check(!dir_bad, "R5 direction and drive during strobe", dir_bad, 0);
                    if (!e.wr) check(rdata == e.rd, "R8 read data", rdata, e.rd);
                end
                low_cnt = 0;
                dir_bad = 1'b0;
            end
        end
    end

    task automatic do_acc(input logic [2:0] a, input logic wr, input logic [15:0] d,
                          input int h, input bit poke, input string tag);
        exp_t e;
        int   n;
        n = exp_wait(a, wr, wait_cfg) + h;
        e.addr = a; e.wr = wr; e.len = 1 + n; e.rd = shadow[a]; e.tag = tag;
        if (wr) shadow[a] = d;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            req_addr = a ^ 3'd5; req_write = !wr; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        ext_hold = (n > 0);
        for (int i = 0; i < n; i++) @(posedge clk);
        if (n > 0) @(negedge clk);
        req_valid = 1'b0;
        ext_hold  = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_en_n && bus_dir && !bus_oe && !done && !busy && bus_addr == 3'd0,
              "R1 reset outputs", {bus_en_n, bus_dir, bus_oe, done, busy, bus_addr}, 8'b1100_0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: no waits configured
        wait_cfg = 14'h0;
        do_acc(3'd1, 1'b1, 16'h1234, 0, 1'b0, "R2 write no wait");
        do_acc(3'd1, 1'b0, 16'h0,    0, 1'b0, "R2 read no wait");
        do_acc(3'd7, 1'b0, 16'h0,    0, 1'b0, "R2 read addr7");

        // R3: codes addr0=01 addr1=10 addr2=11 addr3=00 addr6=11
        wait_cfg = (14'd3 << 12) | (14'd3 << 4) | (14'd2 << 2) | 14'd1;
        do_acc(3'd0, 1'b1, 16'hA0A0, 0, 1'b0, "R3 addr0 write waits");
        do_acc(3'd0, 1'b0, 16'h0,    0, 1'b0, "R3 addr0 read no wait");
        do_acc(3'd1, 1'b1, 16'hB1B1, 0, 1'b0, "R3 addr1 write no wait");
        do_acc(3'd1, 1'b0, 16'h0,    0, 1'b0, "R3 addr1 read waits");
        do_acc(3'd2, 1'b1, 16'hC2C2, 0, 1'b0, "R3 addr2 write waits");
        do_acc(3'd2, 1'b0, 16'h0,    0, 1'b0, "R3 addr2 read waits");
        do_acc(3'd3, 1'b0, 16'h0,    0, 1'b0, "R3 addr3 read no wait");
        do_acc(3'd6, 1'b1, 16'hD6D6, 0, 1'b0, "R3 addr6 write waits");
        do_acc(3'd6, 1'b0, 16'h0,    0, 1'b0, "R3 addr6 read waits");

        // R4: all codes set, address 7 still single cycle
        wait_cfg = 14'h3FFF;
        do_acc(3'd7, 1'b1, 16'h7777, 0, 1'b0, "R4 addr7 write");
        do_acc(3'd7, 1'b0, 16'h0,    0, 1'b0, "R4 addr7 read");
        do_acc(3'd5, 1'b0, 16'h0,    0, 1'b0, "R3 addr5 read all set");

        // R6: hold on top of and without automatic waits
        wait_cfg = (14'd3 << 4);
        do_acc(3'd2, 1'b1, 16'h5A5A, 3, 1'b0, "R6 write wait plus hold");
        do_acc(3'd2, 1'b0, 16'h0,    2, 1'b0, "R6 read wait plus hold");
        do_acc(3'd3, 1'b0, 16'h0,    4, 1'b0, "R6 read hold only");

        // R7: hold while idle does nothing
        begin
            bit quiet;
            quiet = 1'b1;
            @(negedge clk);
            ext_hold = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (!bus_en_n || busy) quiet = 1'b0;
            end
            ext_hold = 1'b0;
            check(quiet, "R7 idle hold ignored", quiet, 1);
        end
        do_acc(3'd4, 1'b0, 16'h0, 0, 1'b0, "R7 access after idle hold");

        // R10: request held during a long access is not taken
        do_acc(3'd1, 1'b1, 16'h0F0F, 4, 1'b1, "R10 poked write");
        repeat (4) @(negedge clk);
        check(sb.size() == 0 && !busy, "R10 no extra access", busy, 0);

        // R9 / R5: idle bus after the last access
        repeat (3) @(negedge clk);
        check(bus_addr == 3'd1, "R9 latched address held", bus_addr, 1);
        check(bus_dir && !bus_oe && bus_en_n, "R5 idle direction", {bus_dir, bus_oe}, 2'b10);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule